// File: doc/BRIEF.md
# DDR2 Bank Command Timing Guard

This block sits between a memory controller's command scheduler and a DDR2 device. On every clock it tells the scheduler which commands may legally go out to each bank. The scheduler presents one command per cycle as a code, a bank index and an auto-precharge bit. The guard updates its per-bank timing state from that command. If the command arrived before its ready flag allowed it, the guard sets a sticky violation flag.

All timing settings come in as run-time configuration that has already been converted to whole clock counts. These are additive latency, CAS latency, burst length (4 or 8), read-to-precharge, active-to-precharge, precharge period, active-to-active and active-to-column delay. The guard also reports the derived read and write latencies.

The earliest precharge after a read does not use a single fixed delay. It is computed from additive latency, burst length and read-to-precharge time. The read-to-precharge time is floored so that the internal precharge never starts earlier than two clocks after the last 4-bit prefetch of the burst.

Top module: `ddr2_cmd_guard`

## Requirements
- R1: During and after reset every bank is closed, every `rdy_act` bit is 1, every `rdy_rd`, `rdy_wr` and `rdy_pre` bit is 0, and `viol` is 0.
- R2: `rd_lat` equals `cfg_al + cfg_cl` and `wr_lat` equals `rd_lat - 1`, for `cfg_cl` of 2 or more (AL=1, CL=3 gives 4; AL=2, CL=3 gives 5).
- R3: An ACTIVE (code 1) opens its bank. READ and WRITE to that bank become ready max(tRCD − AL, 1) clocks after the ACTIVE.
- R4: PRECHARGE to a bank becomes ready max(tRAS, 1) clocks after its ACTIVE. The next ACTIVE to the same bank is held until max(tRC, 1) clocks after the previous ACTIVE.
- R5: A PRECHARGE (code 4) closes its bank. ACTIVE to that bank is held until max(tRP, 1) clocks after the PRECHARGE.
- R6: After a READ (code 2), PRECHARGE of that bank is held until AL + BL/2 + max(tRTP, 2) − 2 clocks after it. BL is 8 when `cfg_bl8` is 1 and 4 otherwise.
- R7: A READ to any bank holds WRITE (code 3) readiness on every bank for BL/2 + 2 clocks.
- R8: A READ or WRITE with `cmd_ap` set closes its bank at once. The implied precharge time P is the later of the remaining PRECHARGE wait and, for a READ only, the R6 delay. ACTIVE is then held until P + tRP clocks after the command.
- R9: A command with code 1 to 4 presented while the matching ready flag of its bank is 0 sets `viol`. This covers a command to a closed bank and an ACTIVE to an open bank. `viol` stays 1 until reset, and the command still updates the bank state.
- R10: Codes 0 and 5 to 7 act as no operation and change no bank state.
- R11: Each bank keeps its own timers. A command to one bank changes no other bank's flags, except the write hold of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_code | input | 3 | Command: 0 none, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE |
| cmd_bank | input | BW | Target bank |
| cmd_ap | input | 1 | Auto-precharge with READ or WRITE |
| cfg_al | input | LW | Additive latency, clocks |
| cfg_cl | input | LW | CAS latency, clocks |
| cfg_bl8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| cfg_trtp | input | TW | Read-to-precharge time, clocks |
| cfg_tras | input | TW | Active-to-precharge time, clocks |
| cfg_trp | input | TW | Precharge period, clocks |
| cfg_trc | input | TW | Active-to-active time, same bank |
| cfg_trcd | input | TW | Active-to-column delay, clocks |
| rdy_act | output | NBANK | ACTIVE allowed, per bank |
| rdy_rd | output | NBANK | READ allowed, per bank |
| rdy_wr | output | NBANK | WRITE allowed, per bank |
| rdy_pre | output | NBANK | PRECHARGE allowed, per bank |
| bank_open | output | NBANK | Bank has an open row |
| viol | output | 1 | Sticky early-command flag |
| rd_lat | output | LW+1 | Read latency |
| wr_lat | output | LW+1 | Write latency |

## Verification
A timer that was loaded wrong or decrements wrong shows up as a ready flag that rises one or more cycles too early or too late. Because the bench compares every ready vector on every cycle, the error appears in the exact cycle the flag should have changed. A wrong open/closed bit shows at once on `bank_open` and inverts the ACTIVE versus column readiness of that bank. A missed early-command detection shows as `viol` still being 0 one cycle after the offending command, and it stays visible until reset.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic ap;
    } bank_req_t;

    // Per-bank request; codes 5..7 decode to nothing (R10)
    function automatic bank_req_t decode_req(logic [2:0] code, logic ap, logic hit);
        bank_req_t r;
        r.act = hit && (code == CMD_ACT);
        r.rd  = hit && (code == CMD_RD);
        r.wr  = hit && (code == CMD_WR);
        r.pre = hit && (code == CMD_PRE);
        r.ap  = hit && ap;
        return r;
    endfunction

endpackage

// File: rtl/ddr2_guard_calc.sv
module ddr2_guard_calc #(
    parameter int LW = 4,
    parameter int TW = 6,
    parameter int CW = TW + 3
) (
    input  logic [LW-1:0] cfg_al,
    input  logic [LW-1:0] cfg_cl,
    input  logic          cfg_bl8,
    input  logic [TW-1:0] cfg_trtp,
    input  logic [TW-1:0] cfg_tras,
    input  logic [TW-1:0] cfg_trp,
    input  logic [TW-1:0] cfg_trc,
    input  logic [TW-1:0] cfg_trcd,
    output logic [CW-1:0] ld_rc,
    output logic [CW-1:0] ld_rp,
    output logic [CW-1:0] ld_ras,
    output logic [CW-1:0] ld_col,
    output logic [CW-1:0] ld_rd2pre,
    output logic [CW-1:0] ld_rd2wr,
    output logic [CW-1:0] n_rd2pre,
    output logic [CW-1:0] n_rp,
    output logic [LW:0]   rd_lat,
    output logic [LW:0]   wr_lat
);
    // A delay of N clocks loads N-1 so the flag rises N cycles later
    function automatic logic [CW-1:0] to_ld(logic [CW-1:0] n);
        return (n == '0) ? '0 : n - CW'(1);
    endfunction

    logic [CW-1:0] half_bl, trtp_eff, al_w, trcd_w;

    always_comb begin
        al_w     = CW'(cfg_al);
        trcd_w   = CW'(cfg_trcd);
        half_bl  = cfg_bl8 ? CW'(4) : CW'(2);
        trtp_eff = (cfg_trtp < TW'(2)) ? CW'(2) : CW'(cfg_trtp);
        n_rd2pre = al_w + half_bl + trtp_eff - CW'(2);
        n_rp     = CW'(cfg_trp);
        ld_rc    = to_ld(CW'(cfg_trc));
        ld_rp    = to_ld(n_rp);
        ld_ras   = to_ld(CW'(cfg_tras));
        ld_col   = (trcd_w > al_w) ? to_ld(trcd_w - al_w) : '0;
        ld_rd2pre = to_ld(n_rd2pre);
        ld_rd2wr = to_ld(half_bl + CW'(2));
        rd_lat   = (LW+1)'(cfg_al) + (LW+1)'(cfg_cl);
        wr_lat   = rd_lat - (LW+1)'(1);
    end
endmodule

// File: rtl/ddr2_bank_timer.sv
module ddr2_bank_timer
    import ddr2_guard_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  bank_req_t     req,
    input  logic [CW-1:0] ld_rc,
    input  logic [CW-1:0] ld_rp,
    input  logic [CW-1:0] ld_ras,
    input  logic [CW-1:0] ld_col,
    input  logic [CW-1:0] ld_rd2pre,
    input  logic [CW-1:0] n_rd2pre,
    input  logic [CW-1:0] n_rp,
    output logic          is_open,
    output logic          act_ok,
    output logic          col_ok,
    output logic          pre_ok
);
    function automatic logic [CW-1:0] dec(logic [CW-1:0] v);
        return (v == '0) ? '0 : v - CW'(1);
    endfunction

    function automatic logic [CW-1:0] later(logic [CW-1:0] a, logic [CW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic [CW-1:0] act_t, col_t, pre_t;
    logic [CW-1:0] act_d, col_d, pre_d;
    logic [CW-1:0] p_imp, imp_sum;
    logic          open_q, open_d;

    always_comb begin
        act_d  = dec(act_t);
        col_d  = dec(col_t);
        pre_d  = dec(pre_t);
        open_d = open_q;
        p_imp  = req.rd ? later(pre_t, n_rd2pre) : pre_t;
        imp_sum = p_imp + n_rp;
        if (req.act) begin
            open_d = 1'b1;
            act_d  = later(act_d, ld_rc);
            col_d  = ld_col;
            pre_d  = ld_ras;
        end
        if (req.pre) begin
            open_d = 1'b0;
            act_d  = later(act_d, ld_rp);
        end
        if (req.rd) begin
            pre_d = later(pre_d, ld_rd2pre);
        end
        if ((req.rd || req.wr) && req.ap) begin
            open_d = 1'b0;
            act_d  = later(act_d, dec(imp_sum));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_t  <= '0;
            col_t  <= '0;
            pre_t  <= '0;
            open_q <= 1'b0;
        end else begin
            act_t  <= act_d;
            col_t  <= col_d;
            pre_t  <= pre_d;
            open_q <= open_d;
        end
    end

    assign is_open = open_q;
    assign act_ok  = !open_q && (act_t == '0);
    assign col_ok  = open_q && (col_t == '0);
    assign pre_ok  = open_q && (pre_t == '0);
endmodule

// File: rtl/ddr2_cmd_guard.sv
module ddr2_cmd_guard
    import ddr2_guard_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int BW    = $clog2(NBANK),
    parameter int LW    = 4,
    parameter int TW    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_code,
    input  logic [BW-1:0]     cmd_bank,
    input  logic              cmd_ap,
    input  logic [LW-1:0]     cfg_al,
    input  logic [LW-1:0]     cfg_cl,
    input  logic              cfg_bl8,
    input  logic [TW-1:0]     cfg_trtp,
    input  logic [TW-1:0]     cfg_tras,
    input  logic [TW-1:0]     cfg_trp,
    input  logic [TW-1:0]     cfg_trc,
    input  logic [TW-1:0]     cfg_trcd,
    output logic [NBANK-1:0]  rdy_act,
    output logic [NBANK-1:0]  rdy_rd,
    output logic [NBANK-1:0]  rdy_wr,
    output logic [NBANK-1:0]  rdy_pre,
    output logic [NBANK-1:0]  bank_open,
    output logic              viol,
    output logic [LW:0]       rd_lat,
    output logic [LW:0]       wr_lat
);
    localparam int CW = TW + 3;

    logic [CW-1:0] ld_rc, ld_rp, ld_ras, ld_col, ld_rd2pre, ld_rd2wr, n_rd2pre, n_rp;
    logic [CW-1:0] wr_t;
    logic [NBANK-1:0] col_ok;
    logic          bad, viol_q;

    ddr2_guard_calc #(.LW(LW), .TW(TW), .CW(CW)) u_calc (
        .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
        .cfg_trtp(cfg_trtp), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
        .cfg_trc(cfg_trc), .cfg_trcd(cfg_trcd),
        .ld_rc(ld_rc), .ld_rp(ld_rp), .ld_ras(ld_ras), .ld_col(ld_col),
        .ld_rd2pre(ld_rd2pre), .ld_rd2wr(ld_rd2wr), .n_rd2pre(n_rd2pre),
        .n_rp(n_rp), .rd_lat(rd_lat), .wr_lat(wr_lat)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_req_t req;
        assign req = decode_req(cmd_code, cmd_ap, cmd_bank == BW'(b));
        ddr2_bank_timer #(.CW(CW)) u_tmr (
            .clk(clk), .rst(rst), .req(req),
            .ld_rc(ld_rc), .ld_rp(ld_rp), .ld_ras(ld_ras), .ld_col(ld_col),
            .ld_rd2pre(ld_rd2pre), .n_rd2pre(n_rd2pre), .n_rp(n_rp),
            .is_open(bank_open[b]), .act_ok(rdy_act[b]),
            .col_ok(col_ok[b]), .pre_ok(rdy_pre[b])
        );
    end

    // Read-to-write turnaround is shared by all banks (data bus)
    always_ff @(posedge clk) begin
        if (rst)                   wr_t <= '0;
        else if (cmd_code == CMD_RD) wr_t <= ld_rd2wr;
        else if (wr_t != '0)       wr_t <= wr_t - CW'(1);
    end

    assign rdy_rd = col_ok;
    assign rdy_wr = col_ok & {NBANK{wr_t == '0}};

    always_comb begin
        case (cmd_code)
            CMD_ACT: bad = !rdy_act[cmd_bank];
            CMD_RD:  bad = !rdy_rd[cmd_bank];
            CMD_WR:  bad = !rdy_wr[cmd_bank];
            CMD_PRE: bad = !rdy_pre[cmd_bank];
            default: bad = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) viol_q <= 1'b0;
        else     viol_q <= viol_q | bad;
    end

    assign viol = viol_q;
endmodule

// File: rtl/ddr2_guard_chk.sv
module ddr2_guard_chk #(
    parameter int NBANK = 8,
    parameter int BW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cmd_code,
    input logic [BW-1:0]    cmd_bank,
    input logic [NBANK-1:0] rdy_act,
    input logic [NBANK-1:0] rdy_rd,
    input logic [NBANK-1:0] rdy_wr,
    input logic [NBANK-1:0] bank_open,
    input logic             viol
);
    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol);

    p_early_read_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd2 && !rdy_rd[cmd_bank]) |=> viol);

    p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd1) |=> bank_open[$past(cmd_bank)]);

    p_pre_closes_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd4) |=> !bank_open[$past(cmd_bank)]);

    p_read_holds_write_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd2) |=> (rdy_wr == '0));

    p_wr_within_rd_r7: assert property (@(posedge clk) disable iff (rst)
        (rdy_wr & ~rdy_rd) == '0);

    p_act_only_closed_r5: assert property (@(posedge clk) disable iff (rst)
        (rdy_act & bank_open) == '0);

    p_idle_code_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_code > 3'd4) |=> (bank_open == $past(bank_open)));
endmodule

bind ddr2_cmd_guard ddr2_guard_chk #(.NBANK(NBANK), .BW(BW)) u_chk (
    .clk(clk), .rst(rst), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .rdy_act(rdy_act), .rdy_rd(rdy_rd), .rdy_wr(rdy_wr),
    .bank_open(bank_open), .viol(viol)
);

// File: tb/sim_ddr2_cmd_guard.sv
module sim_ddr2_cmd_guard;
    localparam int CLK_P = 10;
    localparam int NB = 8;

    logic clk = 0, rst = 1;
    logic [2:0] cmd_code = 0;
    logic [2:0] cmd_bank = 0;
    logic cmd_ap = 0;
    logic [3:0] cfg_al = 0, cfg_cl = 3;
    logic cfg_bl8 = 0;
    logic [5:0] cfg_trtp = 2, cfg_tras = 6, cfg_trp = 3, cfg_trc = 9, cfg_trcd = 3;
    logic [NB-1:0] rdy_act, rdy_rd, rdy_wr, rdy_pre, bank_open;
    logic viol;
    logic [4:0] rd_lat, wr_lat;

    always #(CLK_P/2) clk = ~clk;

    ddr2_cmd_guard u0 (
        .clk(clk), .rst(rst), .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
        .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8), .cfg_trtp(cfg_trtp),
        .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_trc(cfg_trc), .cfg_trcd(cfg_trcd),
        .rdy_act(rdy_act), .rdy_rd(rdy_rd), .rdy_wr(rdy_wr), .rdy_pre(rdy_pre),
        .bank_open(bank_open), .viol(viol), .rd_lat(rd_lat), .wr_lat(wr_lat)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int cyc;
    int ea_act[NB], ea_col[NB], ea_pre[NB];
    bit mopen[NB];
    int ea_wr;
    bit mviol;

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int half_bl();
        return cfg_bl8 ? 4 : 2;
    endfunction

    function automatic bit m_rdy(int c, int b);
        case (c)
            1: return !mopen[b] && cyc >= ea_act[b];
            2: return mopen[b] && cyc >= ea_col[b];
            3: return mopen[b] && cyc >= ea_col[b] && cyc >= ea_wr;
            4: return mopen[b] && cyc >= ea_pre[b];
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        cyc = 0; ea_wr = 0; mviol = 0;
        for (int b = 0; b < NB; b++) begin
            ea_act[b] = 0; ea_col[b] = 0; ea_pre[b] = 0; mopen[b] = 0;
        end
    endtask

    task automatic model_step(int c, int b, bit ap);
        int al, nrd, pold, p;
        bit closing;
        al = int'(cfg_al);
        closing = 0; p = 0;
        if (c >= 1 && c <= 4 && !m_rdy(c, b)) mviol = 1;
        pold = mx(ea_pre[b] - cyc, 0);
        nrd = al + half_bl() + mx(int'(cfg_trtp), 2) - 2;
        case (c)
            1: begin
                mopen[b] = 1;
                ea_col[b] = cyc + mx(int'(cfg_trcd) - al, 1);
                ea_pre[b] = cyc + mx(int'(cfg_tras), 1);
                ea_act[b] = mx(ea_act[b], cyc + mx(int'(cfg_trc), 1));
            end
            2: begin
                ea_wr = cyc + half_bl() + 2;
                ea_pre[b] = mx(ea_pre[b], cyc + mx(nrd, 1));
                if (ap) begin closing = 1; p = mx(pold, nrd); end
            end
            3: if (ap) begin closing = 1; p = pold; end
            4: begin
                mopen[b] = 0;
                ea_act[b] = mx(ea_act[b], cyc + mx(int'(cfg_trp), 1));
            end
            default: ;
        endcase
        if (closing) begin
            mopen[b] = 0;
            ea_act[b] = mx(ea_act[b], cyc + mx(p + int'(cfg_trp), 1));
        end
    endtask

    task automatic check_all();
        logic [NB-1:0] ea, er, ew, ep, eo;
        for (int b = 0; b < NB; b++) begin
            ea[b] = m_rdy(1, b); er[b] = m_rdy(2, b);
            ew[b] = m_rdy(3, b); ep[b] = m_rdy(4, b); eo[b] = mopen[b];
        end
        chk(rdy_act == ea, "R4 R5 R8 ACT ready", rdy_act, ea);
        chk(rdy_rd == er, "R3 READ ready", rdy_rd, er);
        chk(rdy_wr == ew, "R7 WRITE ready", rdy_wr, ew);
        chk(rdy_pre == ep, "R4 R6 PRE ready", rdy_pre, ep);
        chk(bank_open == eo, "R5 R8 R10 R11 open", bank_open, eo);
        chk(viol == mviol, "R9 violation", viol, mviol);
    endtask

    task automatic do_reset();
        rst = 1; cmd_code = 0; cmd_ap = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(rdy_act == '1 && rdy_rd == '0 && rdy_wr == '0 && rdy_pre == '0 &&
            bank_open == '0 && viol == 0, "R1 reset state",
            {rdy_act, rdy_rd, rdy_wr, rdy_pre, bank_open}, {8'hFF, 32'h0});
        rst = 0;
        model_reset();
    endtask

    task automatic run_seg(int n, bit allow_bad);
        for (int i = 0; i < n; i++) begin
            int r, c, b, cnt;
            int list[4];
            check_all();
            r = $urandom_range(99);
            b = $urandom_range(NB-1);
            c = 0;
            if (r < 40) c = 0;
            else if (r < 42 && allow_bad && i > n/2) c = $urandom_range(7);
            else if (r < 46) c = 5 + $urandom_range(2);
            else begin
                cnt = 0;
                for (int k = 1; k <= 4; k++) if (m_rdy(k, b)) begin list[cnt] = k; cnt++; end
                if (cnt > 0) c = list[$urandom_range(cnt-1)];
            end
            cmd_code = 3'(c); cmd_bank = 3'(b); cmd_ap = ($urandom_range(3) == 0);
            model_step(c, b, cmd_ap);
            cyc++;
            @(negedge clk);
        end
        cmd_code = 0;
    endtask

    task automatic set_cfg(int al, int cl, bit bl8, int rtp, int ras, int rp, int rc, int rcd);
        cfg_al = 4'(al); cfg_cl = 4'(cl); cfg_bl8 = bl8; cfg_trtp = 6'(rtp);
        cfg_tras = 6'(ras); cfg_trp = 6'(rp); cfg_trc = 6'(rc); cfg_trcd = 6'(rcd);
    endtask

    task automatic issue(int c, int b, bit ap);
        check_all();
        cmd_code = 3'(c); cmd_bank = 3'(b); cmd_ap = ap;
        model_step(c, b, ap);
        cyc++;
        @(negedge clk);
        cmd_code = 0; cmd_ap = 0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        // Directed: AL=1 CL=3 BL4 tRTP=2 -> RL 4, WL 3, read-to-precharge 3
        set_cfg(1, 3, 0, 2, 4, 3, 8, 3);
        do_reset();
        chk(rd_lat == 4 && wr_lat == 3, "R2 latency AL1 CL3", {rd_lat, wr_lat}, {5'd4, 5'd3});
        issue(1, 2, 0);
        repeat (5) issue(0, 0, 0);
        issue(2, 2, 0);
        chk(rdy_pre[2] == 0, "R6 pre held after read", rdy_pre[2], 0);
        issue(0, 0, 0);
        issue(0, 0, 0);
        chk(rdy_pre[2] == 1, "R6 pre ready at 3 clocks", rdy_pre[2], 1);
        issue(3, 5, 0);
        chk(viol == 1, "R9 write to closed bank", viol, 1);
        run_seg(40, 0);
        // Directed: AL=2 CL=3 -> RL 5; BL8, tRTP 0 clamped to 2; auto-precharge read
        set_cfg(2, 3, 1, 0, 3, 4, 5, 5);
        do_reset();
        chk(rd_lat == 5 && wr_lat == 4, "R2 latency AL2 CL3", {rd_lat, wr_lat}, {5'd5, 5'd4});
        issue(1, 0, 0);
        issue(1, 1, 0);
        issue(0, 0, 0);
        issue(2, 0, 1);
        chk(bank_open == 8'h02, "R8 auto-precharge closes", bank_open, 8'h02);
        chk(rdy_wr == 8'h00, "R7 write held after read", rdy_wr, 0);
        issue(7, 1, 0);
        chk(bank_open == 8'h02, "R10 code 7 ignored", bank_open, 8'h02);
        run_seg(60, 0);
        // Random segments
        for (int s = 0; s < 24; s++) begin
            set_cfg($urandom_range(4), 3 + $urandom_range(3), $urandom_range(1),
                    $urandom_range(4), 1 + $urandom_range(11), 1 + $urandom_range(5),
                    1 + $urandom_range(17), 1 + $urandom_range(5));
            do_reset();
            chk(int'(rd_lat) == int'(cfg_al) + int'(cfg_cl) && int'(wr_lat) == int'(rd_lat) - 1,
                "R2 latency", {rd_lat, wr_lat}, int'(cfg_al) + int'(cfg_cl));
            run_seg(300, 1);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule